// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Interrupt Triggers

This block gives software a bank of general-purpose pins behind a small 32-bit register port. Every pin has a driven value, a direction bit that turns its pad driver on, and a readback of the level seen on the pad. The readback passes through a two-stage synchronizer first. The pad cell itself is not part of the block. The block brings out the value to drive and the driver enable as plain ports.

Each pin can also raise an interrupt. Its trigger is chosen by a 3-bit code held in a 4-bit slot of one of two mode words. The choices are a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a sticky status bit when the pin is enabled. Software clears a status bit by writing a one to it. A separate pair of write-one registers sets and clears a per-pin mask. The unmasked status bits are ORed into a single registered interrupt line. A soft-reset register that is written high and then low puts every configuration and status bit back to zero.

Writes take effect on the clock edge at which `bus_wen` is sampled high. Read data is registered and shows, one cycle after the address is presented, the register that the address selects.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After the synchronous reset, every register reads 0, `pad_oe` and `pad_out` are 0 and `irq_out` is low.
- R2: The word index is `bus_addr[5:2]`: 0 enable, 1 status, 2 masked status (display), 3 status clear, 4 mask set, 5 mask clear, 6 output value, 7 input level, 8 direction, 9 low mode word, 10 high mode word, 14 pin-use select, 15 soft reset. Indices 11 to 13 read 0. Indices 4 and 5 both read the current mask. Only bits 0 to NPIN-1 are kept, and higher bits read 0.
- R3: `pad_oe` equals the direction register and `pad_out` equals the output register. Both update on the write edge.
- R4: The input register reads the pad levels, bit k for pin k, two clock edges after they are applied.
- R5: Trigger codes: 0 falling edge, 1 rising edge, 4 either edge. An edge is found by comparing the synchronized level with its value one cycle earlier.
- R6: Code 2 (low) and code 3 (high) set the status bit on every cycle the level is present. A clear written while the level is still present therefore does not stick.
- R7: Trigger codes 5, 6 and 7 never set a status bit.
- R8: The code of pin k sits in bits 4*k+2..4*k of the low mode word for k < 8, and in bits 4*(k-8)+2..4*(k-8) of the high mode word for k >= 8. Bit 3 of each slot reads 0.
- R9: A status bit is set only while the pin's enable bit is 1.
- R10: Writing 1 to a bit of mask-set masks that pin, and writing 1 to the same bit of mask-clear unmasks it. Zero bits change nothing. The display register reads status AND NOT mask, and `irq_out` is the registered OR of those bits.
- R11: Writing 1 to a bit of the status-clear word clears that status bit. Zero bits leave the status unchanged.
- R12: While soft-reset bit 0 reads 1, all configuration, mask and status bits are held at 0 and writes to them are ignored. Writing 0 to the soft-reset register releases them.
- R13: With NPIN = 8, the high mode word and all bits from 8 upward read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 6 | Byte address; bits 5:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the address in the previous cycle |
| pad_in | input | NPIN | Levels seen on the pads |
| pad_out | output | NPIN | Value for each pad driver |
| pad_oe | output | NPIN | Driver enable for each pad (1 = output) |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds two copies that share one bus and the low pad bits: the default twelve-pin controller and an eight-pin one. With twelve pins, the high mode word and a pin whose trigger is configured there are both used, so the split of trigger codes across the two words is checked. The eight-pin copy reads back the same writes, so the bench can see the high mode word and the upper bits read as zero when no pins exist there.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int BUS_AW   = 6;
  localparam int BUS_DW   = 32;
  localparam int IDX_W    = 4;
  localparam int MODE_W   = 3;
  localparam int SLOT_W   = 4;
  localparam int SLOTS_PER_WORD = BUS_DW / SLOT_W;

  // register word indices (bus_addr[5:2])
  localparam logic [IDX_W-1:0] RI_ENABLE  = 4'h0;
  localparam logic [IDX_W-1:0] RI_STATUS  = 4'h1;
  localparam logic [IDX_W-1:0] RI_DISPLAY = 4'h2;
  localparam logic [IDX_W-1:0] RI_CLEAR   = 4'h3;
  localparam logic [IDX_W-1:0] RI_MSET    = 4'h4;
  localparam logic [IDX_W-1:0] RI_MCLR    = 4'h5;
  localparam logic [IDX_W-1:0] RI_OUTVAL  = 4'h6;
  localparam logic [IDX_W-1:0] RI_INLVL   = 4'h7;
  localparam logic [IDX_W-1:0] RI_DIR     = 4'h8;
  localparam logic [IDX_W-1:0] RI_MODE_LO = 4'h9;
  localparam logic [IDX_W-1:0] RI_MODE_HI = 4'hA;
  localparam logic [IDX_W-1:0] RI_PINSEL  = 4'hE;
  localparam logic [IDX_W-1:0] RI_SOFTRST = 4'hF;

  // trigger codes
  localparam logic [MODE_W-1:0] TRG_FALL = 3'd0;
  localparam logic [MODE_W-1:0] TRG_RISE = 3'd1;
  localparam logic [MODE_W-1:0] TRG_LOW  = 3'd2;
  localparam logic [MODE_W-1:0] TRG_HIGH = 3'd3;
  localparam logic [MODE_W-1:0] TRG_ANY  = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPIN-1:0]              lvl,
  input  logic [NPIN-1:0][MODE_W-1:0]  mode,
  output logic [NPIN-1:0]              hit
);
  logic [NPIN-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    logic rise_w, fall_w, hit_w;
    assign rise_w = lvl[k] & ~prev_q[k];
    assign fall_w = ~lvl[k] & prev_q[k];
    always_comb begin
      case (mode[k])
        TRG_FALL: hit_w = fall_w;
        TRG_RISE: hit_w = rise_w;
        TRG_LOW:  hit_w = ~lvl[k];
        TRG_HIGH: hit_w = lvl[k];
        TRG_ANY:  hit_w = rise_w | fall_w;
        default:  hit_w = 1'b0;
      endcase
    end
    assign hit[k] = hit_w;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq_out
);
  localparam int MODE_WORDS = 2;

  logic [IDX_W-1:0]              widx;
  logic                          cfg_clr;
  logic                          srst_q;
  logic [NPIN-1:0]               ien_q, istat_q, imask_q, po_q, pm_q, pinsel_q;
  logic [NPIN-1:0][MODE_W-1:0]   mode_q;
  logic [NPIN-1:0]               lvl_sync, hit, set_v, clr_v, mset_v, mclr_v, shown;
  logic [MODE_WORDS-1:0][31:0]   mode_rd;
  logic [31:0]                   rd_v;
  logic                          unused_bits;

  assign widx        = bus_addr[5:2];
  assign cfg_clr     = rst | srst_q;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  function automatic logic wr_hit(input logic [IDX_W-1:0] idx);
    return bus_wen && (widx == idx);
  endfunction

  gpio_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_sync)
  );

  gpio_trig_detect #(.NPIN(NPIN)) u_detect (
    .clk  (clk),
    .rst  (rst),
    .lvl  (lvl_sync),
    .mode (mode_q),
    .hit  (hit)
  );

  // soft reset register: only hard reset clears it
  always_ff @(posedge clk) begin
    if (rst)                  srst_q <= 1'b0;
    else if (wr_hit(RI_SOFTRST)) srst_q <= bus_wdata[0];
  end

  // plain configuration registers
  always_ff @(posedge clk) begin
    if (cfg_clr) begin
      ien_q    <= '0;
      po_q     <= '0;
      pm_q     <= '0;
      pinsel_q <= '0;
    end else begin
      if (wr_hit(RI_ENABLE)) ien_q    <= bus_wdata[NPIN-1:0];
      if (wr_hit(RI_OUTVAL)) po_q     <= bus_wdata[NPIN-1:0];
      if (wr_hit(RI_DIR))    pm_q     <= bus_wdata[NPIN-1:0];
      if (wr_hit(RI_PINSEL)) pinsel_q <= bus_wdata[NPIN-1:0];
    end
  end

  // per-pin trigger codes in two mode words
  for (genvar k = 0; k < NPIN; k++) begin : g_mode
    localparam int SLOT = k % SLOTS_PER_WORD;
    localparam logic [IDX_W-1:0] SEL = (k < SLOTS_PER_WORD) ? RI_MODE_LO : RI_MODE_HI;
    always_ff @(posedge clk) begin
      if (cfg_clr)          mode_q[k] <= '0;
      else if (wr_hit(SEL)) mode_q[k] <= bus_wdata[SLOT*SLOT_W +: MODE_W];
    end
  end

  always_comb begin
    mode_rd = '0;
    for (int k = 0; k < NPIN; k++) begin
      mode_rd[k / SLOTS_PER_WORD][(k % SLOTS_PER_WORD)*SLOT_W +: SLOT_W] = {1'b0, mode_q[k]};
    end
  end

  // status, mask and combined request
  assign set_v  = ien_q & hit;
  assign clr_v  = wr_hit(RI_CLEAR) ? bus_wdata[NPIN-1:0] : '0;
  assign mset_v = wr_hit(RI_MSET)  ? bus_wdata[NPIN-1:0] : '0;
  assign mclr_v = wr_hit(RI_MCLR)  ? bus_wdata[NPIN-1:0] : '0;
  assign shown  = istat_q & ~imask_q;

  always_ff @(posedge clk) begin
    if (cfg_clr) begin
      istat_q <= '0;
      imask_q <= '0;
      irq_out <= 1'b0;
    end else begin
      istat_q <= (istat_q & ~clr_v) | set_v;
      imask_q <= (imask_q | mset_v) & ~mclr_v;
      irq_out <= |shown;
    end
  end

  // read mux, registered
  always_comb begin
    rd_v = '0;
    case (widx)
      RI_ENABLE:          rd_v[NPIN-1:0] = ien_q;
      RI_STATUS:          rd_v[NPIN-1:0] = istat_q;
      RI_DISPLAY:         rd_v[NPIN-1:0] = shown;
      RI_MSET, RI_MCLR:   rd_v[NPIN-1:0] = imask_q;
      RI_OUTVAL:          rd_v[NPIN-1:0] = po_q;
      RI_INLVL:           rd_v[NPIN-1:0] = lvl_sync;
      RI_DIR:             rd_v[NPIN-1:0] = pm_q;
      RI_MODE_LO:         rd_v = mode_rd[0];
      RI_MODE_HI:         rd_v = mode_rd[1];
      RI_PINSEL:          rd_v[NPIN-1:0] = pinsel_q;
      RI_SOFTRST:         rd_v[0] = srst_q;
      default:            rd_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_v;
  end

  assign pad_out = po_q;
  assign pad_oe  = pm_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wen,
  input logic [5:0]      bus_addr,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] pad_oe,
  input logic            irq_out,
  input logic            srst_q,
  input logic [NPIN-1:0] ien_q,
  input logic [NPIN-1:0] istat_q,
  input logic [NPIN-1:0] imask_q,
  input logic [NPIN-1:0] pm_q
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pad_oe == '0) && !irq_out && (istat_q == '0));

  // R3
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr[5:2] == 4'h8 && !srst_q) |=> pad_oe == $past(bus_wdata[NPIN-1:0]));

  // R9
  no_set_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ien_q == '0) |=> (istat_q & ~$past(istat_q)) == '0);

  // R10
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr[5:2] == 4'h4 && !srst_q)
      |=> (imask_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0]));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((istat_q & ~imask_q) == '0) |=> !irq_out);

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (ien_q == '0) && (istat_q == '0) && (imask_q == '0) && (pm_q == '0) && !irq_out);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wen   (bus_wen),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .irq_out   (irq_out),
  .srst_q    (srst_q),
  .ien_q     (ien_q),
  .istat_q   (istat_q),
  .imask_q   (imask_q),
  .pm_q      (pm_q)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
  localparam int NP  = 12;
  localparam int NP8 = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              wen = 1'b0;
  logic [5:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata12, rdata8;
  logic [NP-1:0]     pad_in = '0;
  logic [NP-1:0]     pad_out, pad_oe;
  logic [NP8-1:0]    pout8, poe8;
  logic              irq, irq8;

  gpio_irq_ctrl #(.NPIN(NP)) uut (
    .clk(clk), .rst(rst), .bus_wen(wen), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata12), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq));

  gpio_irq_ctrl #(.NPIN(NP8)) uut8 (
    .clk(clk), .rst(rst), .bus_wen(wen), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata8), .pad_in(pad_in[NP8-1:0]), .pad_out(pout8), .pad_oe(poe8), .irq_out(irq8));

  int checks = 0;
  int fails  = 0;

  // scoreboard queues
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          sel_q[$];
  logic        rd_req = 1'b0;
  logic        rd_q   = 1'b0;
  logic [31:0] mon_e, mon_a;
  string       mon_t;
  bit          mon_s;

  always @(posedge clk) rd_q <= rd_req;

  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL scoreboard: read without expectation actual=%h expected=none", rdata12);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        mon_s = sel_q.pop_front();
        mon_a = mon_s ? rdata8 : rdata12;
        checks++;
        if (mon_a !== mon_e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", mon_t, mon_a, mon_e);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [5:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t); sel_q.push_back(s);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk(input logic [31:0] a, input logic [31:0] e, input string t);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [NP-1:0] v);
    @(negedge clk);
    pad_in = v;
    idle(5);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq_out");
    chk({20'd0, pad_oe}, 32'd0, "R1 pad_oe");
    chk({20'd0, pad_out}, 32'd0, "R1 pad_out");
    rd(0, 6'h00, 32'h0, "R1 enable");
    rd(0, 6'h04, 32'h0, "R1 status");
    rd(0, 6'h10, 32'h0, "R1 mask");
    rd(0, 6'h20, 32'h0, "R1 direction");
    rd(0, 6'h24, 32'h0, "R1 mode low");
    rd(0, 6'h3C, 32'h0, "R1 soft reset");
    rd(0, 6'h1C, 32'h0, "R1 input");

    // R2 R3 direction and output
    wr(6'h20, 32'hFFFF_FFFF);
    chk({20'd0, pad_oe}, 32'hFFF, "R3 pad_oe all");
    rd(0, 6'h20, 32'h0000_0FFF, "R2 direction width");
    rd(1, 6'h20, 32'h0000_00FF, "R13 direction width 8 pins");
    wr(6'h18, 32'h0000_0A5A);
    chk({20'd0, pad_out}, 32'hA5A, "R3 pad_out");
    rd(0, 6'h18, 32'h0000_0A5A, "R2 output readback");
    wr(6'h20, 32'h0000_000F);
    chk({20'd0, pad_oe}, 32'h00F, "R3 pad_oe partial");
    wr(6'h38, 32'hFFFF_FFFF);
    rd(0, 6'h38, 32'h0000_0FFF, "R2 pin-use select");
    rd(0, 6'h2C, 32'h0, "R2 reserved word");

    // R4 input path
    drive(12'h3C3);
    rd(0, 6'h1C, 32'h0000_03C3, "R4 input level");
    rd(1, 6'h1C, 32'h0000_00C3, "R13 input level 8 pins");
    drive(12'h000);

    // R8 mode slots
    wr(6'h24, 32'h1754_3210);
    rd(0, 6'h24, 32'h1754_3210, "R8 mode low word");
    wr(6'h28, 32'hFFFF_FFFF);
    rd(0, 6'h28, 32'h0000_7777, "R8 mode high slot top bit");
    rd(1, 6'h28, 32'h0, "R13 mode high word 8 pins");
    wr(6'h28, 32'h0000_0011);
    rd(0, 6'h28, 32'h0000_0011, "R8 mode high word");

    // R9 edge with enable off
    drive(12'h002);
    rd(0, 6'h04, 32'h0, "R9 no status when disabled");
    drive(12'h000);

    // R6 low level latches once enabled
    wr(6'h00, 32'h0000_0FFF);
    idle(3);
    rd(0, 6'h04, 32'h0000_0004, "R6 low level");
    chk({31'd0, irq}, 32'd1, "R10 irq_out raised");
    wr(6'h0C, 32'h0000_0004);
    rd(0, 6'h04, 32'h0000_0004, "R6 clear while level held");

    // R6 high level; R11 clear
    drive(12'h00C);
    rd(0, 6'h04, 32'h0000_000C, "R6 high level");
    wr(6'h0C, 32'h0000_0004);
    rd(0, 6'h04, 32'h0000_0008, "R11 clear one bit");
    wr(6'h0C, 32'h0000_0000);
    rd(0, 6'h04, 32'h0000_0008, "R11 zero write ignored");

    // R5 R7 edges
    drive(12'h07F);
    rd(0, 6'h04, 32'h0000_001A, "R5 R7 rising edges");
    drive(12'h00E);
    rd(0, 6'h04, 32'h0000_001B, "R5 R7 falling edges");

    // R10 masking
    wr(6'h10, 32'h0000_001B);
    idle(2);
    rd(0, 6'h08, 32'h0, "R10 display all masked");
    chk({31'd0, irq}, 32'd0, "R10 irq_out masked");
    wr(6'h10, 32'h0000_0000);
    rd(0, 6'h10, 32'h0000_001B, "R10 mask zero write ignored");
    wr(6'h14, 32'h0000_0002);
    idle(2);
    rd(0, 6'h08, 32'h0000_0002, "R10 display after unmask");
    rd(0, 6'h14, 32'h0000_0019, "R10 mask after clear");
    chk({31'd0, irq}, 32'd1, "R10 irq_out unmasked");

    // R5 rising edge on a high-word pin
    drive(12'h10E);
    rd(0, 6'h04, 32'h0000_011B, "R5 pin 8 rising");
    rd(0, 6'h08, 32'h0000_0102, "R10 display pin 8");
    rd(1, 6'h04, 32'h0000_001B, "R13 status 8 pins");
    wr(6'h0C, 32'h0000_0FFF);
    rd(0, 6'h04, 32'h0000_0008, "R11 R6 clear all with level");

    // R12 soft reset
    wr(6'h3C, 32'h0000_0001);
    rd(0, 6'h3C, 32'h0000_0001, "R12 soft reset held");
    wr(6'h00, 32'h0000_0FFF);
    rd(0, 6'h00, 32'h0, "R12 write ignored while held");
    wr(6'h3C, 32'h0000_0000);
    idle(3);
    rd(0, 6'h04, 32'h0, "R12 status cleared");
    rd(0, 6'h10, 32'h0, "R12 mask cleared");
    rd(0, 6'h20, 32'h0, "R12 direction cleared");
    rd(0, 6'h24, 32'h0, "R12 mode cleared");
    rd(0, 6'h18, 32'h0, "R12 output cleared");
    rd(0, 6'h3C, 32'h0, "R12 soft reset released");
    chk({20'd0, pad_oe}, 32'h0, "R12 pad_oe");
    chk({31'd0, irq}, 32'd0, "R12 irq_out");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule